// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the datapath half of a multi-cycle, microprogrammed 32-bit processor. All movement of data goes over one shared 32-bit bus. Four sources can drive that bus: the ALU result, the register file read port, the memory read data and the immediate extender. Four registers can capture from it: the instruction register, the two ALU operand registers A and B, and the memory address register. The register file has 32 general registers and keeps the program counter as one extra entry. It is addressed through a small select code that picks an instruction field or a fixed entry.

Every driver enable, load strobe and select is a plain input. An external microsequencer, or a bench, therefore performs one register transfer per clock. For its dispatch and branch decisions, the sequencer gets back the instruction opcode and a flag that is high when A is zero. Memory lives outside the block. The block presents the address register, the bus value as write data, and pass-through write and request strobes. The memory answers with read data and a busy flag, and that flag is relayed to the sequencer.

Jump targets are not built by dedicated logic. One ALU function merges the top of A with the shifted low part of B, so the program counter can be reloaded from the bus like any other register.

Top module: `sbus_datapath`

## Requirements
- R1: After reset the following all read as zero: the instruction register, A, B, the address register and all 33 register-file entries. As a result, `opcode` is 0, `a_zero` is 1 and `mem_addr` is 0.
- R2: When exactly one of `drv_alu`, `drv_reg`, `drv_mem` and `drv_imm` is high, the bus (seen on `mem_wdata`) equals that source in the same cycle. When none is high, the bus is zero.
- R3: `bus_conflict` is high in any cycle where two or more bus drivers are enabled, and low otherwise.
- R4: On a rising edge, each of `ld_ir`, `ld_a`, `ld_b` and `ld_ma` copies the bus into its register. A register whose strobe is low keeps its value.
- R5: `reg_src` selects the register-file entry as follows: 0 = the IR field rs (bits 25:21), 1 = the field rt (bits 20:16), 2 = the field rd (bits 15:11), 3 = the program counter (entry 32), 4 = the link register (entry 31). With `reg_we` high, the selected entry takes the bus value at the edge.
- R6: Entry 0 always reads as zero, even after a write to it.
- R7: The immediate extender works on IR bits 15:0. `imm_mode` selects the form: 0 gives the sign-extended value, 1 gives the zero-extended value, 2 gives the sign-extended value shifted left by 2, and 3 gives zero.
- R8: `alu_fn` selects the ALU function: 0 passes A, 1 gives A+B (modulo 2^32), 2 gives A+4, and 3 gives the jump target {A[31:28], B[25:0], 2'b00}.
- R9: `mem_addr` is the address register and `mem_wdata` is the bus. `mem_wr` follows `mem_we`, `mem_req` follows `mem_en`, and `mem_wait` follows `mem_busy`, all in the same cycle.
- R10: `opcode` is IR bits 31:26. `a_zero` is high exactly when A is zero.
- R11: `reg_src` codes 5 to 7 read as zero, and a write through them changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_reg | input | 1 | Register-file read port drives the bus |
| drv_mem | input | 1 | Memory read data drives the bus |
| drv_imm | input | 1 | Immediate extender drives the bus |
| ld_ir | input | 1 | Instruction register captures the bus |
| ld_a | input | 1 | Operand A captures the bus |
| ld_b | input | 1 | Operand B captures the bus |
| ld_ma | input | 1 | Address register captures the bus |
| reg_src | input | 3 | Register-file entry select code |
| reg_we | input | 1 | Write the bus into the selected entry |
| imm_mode | input | 2 | Immediate extension form |
| alu_fn | input | 2 | ALU function |
| mem_we | input | 1 | Write (1) / read (0) request from the sequencer |
| mem_en | input | 1 | Memory access enable from the sequencer |
| mem_rdata | input | 32 | Read data from memory |
| mem_busy | input | 1 | Memory access in progress |
| mem_addr | output | 32 | Memory address (address register) |
| mem_wdata | output | 32 | Write data (the bus) |
| mem_wr | output | 1 | Write/read select to memory |
| mem_req | output | 1 | Access enable to memory |
| mem_wait | output | 1 | Memory busy relayed to the sequencer |
| opcode | output | 6 | Instruction opcode field |
| a_zero | output | 1 | A register equals zero |
| bus_conflict | output | 1 | More than one bus driver enabled |

## Verification
The bench loads arbitrary values from the memory-read source. This lets it check every bus source alone, no source at all, and several sources at once, which separates a correct single-driver result from an OR of sources and from a missed conflict flag.

Register writes and reads go through all five select codes, using IR fields that differ from one another. A swapped field slice or a wrong fixed index for the program counter or the link register therefore gives a wrong readback.

The immediate extender is given values with bit 15 set and with bit 15 clear, which tells sign extension from zero extension. The ALU is given A and B with distinct upper and lower bits, which exposes a wrong slice or shift in the jump-target merge.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

   typedef enum logic [2:0] {
      SRC_RS   = 3'd0,
      SRC_RT   = 3'd1,
      SRC_RD   = 3'd2,
      SRC_PC   = 3'd3,
      SRC_LINK = 3'd4
   } reg_src_e;

   typedef enum logic [1:0] {
      IMM_SX     = 2'd0,
      IMM_ZX     = 2'd1,
      IMM_SX_SH  = 2'd2,
      IMM_OFF    = 2'd3
   } imm_mode_e;

   typedef enum logic [1:0] {
      ALU_PASS = 2'd0,
      ALU_ADD  = 2'd1,
      ALU_STEP = 2'd2,
      ALU_JUMP = 2'd3
   } alu_fn_e;

   localparam int NUM_DRIVERS = 4;

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
   parameter int DATA_W    = 32,
   parameter int NUM_GPR   = 32,
   parameter bit ZERO_R0   = 1'b1,
   parameter int IDX_W     = $clog2(NUM_GPR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic              idx_ok,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int NUM_ENT = NUM_GPR + 1;

   generate
      if (NUM_GPR < 2) begin : g_bad_depth
         $error("sbus_regfile: NUM_GPR must be at least 2");
      end
      if ((1 << IDX_W) < NUM_ENT) begin : g_bad_idx
         $error("sbus_regfile: IDX_W too narrow for NUM_GPR+1 entries");
      end
   endgenerate

   logic [DATA_W-1:0] ent_q [NUM_ENT];
   logic              in_range;
   logic              wr_block;
   logic [DATA_W-1:0] raw_rd;

   assign in_range = idx_ok && (int'(idx) < NUM_ENT);

   generate
      if (ZERO_R0) begin : g_r0_fixed
         assign wr_block = (idx == '0);
         assign rd_data  = (idx == '0) ? '0 : raw_rd;
      end else begin : g_r0_plain
         assign wr_block = 1'b0;
         assign rd_data  = raw_rd;
      end
   endgenerate

   always_comb begin
      raw_rd = '0;
      if (in_range) raw_rd = ent_q[idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_ENT; i++) ent_q[i] <= '0;
      end else if (wr_en && in_range && !wr_block) begin
         ent_q[idx] <= wr_data;
      end
   end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
   import sbus_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int STEP     = 4,
   parameter int TOP_KEEP = 4,
   parameter int LOW_SH   = 2
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [1:0]        fn,
   output logic [DATA_W-1:0] y
);

   localparam logic [DATA_W-1:0] TOP_MASK = ~({DATA_W{1'b1}} >> TOP_KEEP);
   localparam logic [DATA_W-1:0] STEP_V   = DATA_W'(STEP);

   generate
      if (TOP_KEEP + LOW_SH >= DATA_W) begin : g_bad_split
         $error("sbus_alu: jump merge fields exceed the data width");
      end
   endgenerate

   always_comb begin
      unique case (alu_fn_e'(fn))
         ALU_PASS: y = a;
         ALU_ADD:  y = a + b;
         ALU_STEP: y = a + STEP_V;
         ALU_JUMP: y = (a & TOP_MASK) | ((b << LOW_SH) & ~TOP_MASK);
         default:  y = '0;
      endcase
   end

endmodule

// File: rtl/sbus_immext.sv
module sbus_immext
   import sbus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16,
   parameter int SH     = 2
) (
   input  logic [IMM_W-1:0]  field,
   input  logic [1:0]        mode,
   output logic [DATA_W-1:0] y
);

   generate
      if (IMM_W >= DATA_W) begin : g_bad_imm
         $error("sbus_immext: immediate must be narrower than the data path");
      end
   endgenerate

   logic [DATA_W-1:0] sx;
   logic [DATA_W-1:0] zx;

   assign sx = {{(DATA_W-IMM_W){field[IMM_W-1]}}, field};
   assign zx = {{(DATA_W-IMM_W){1'b0}}, field};

   always_comb begin
      unique case (imm_mode_e'(mode))
         IMM_SX:    y = sx;
         IMM_ZX:    y = zx;
         IMM_SX_SH: y = sx << SH;
         IMM_OFF:   y = '0;
         default:   y = '0;
      endcase
   end

endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
   import sbus_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NUM_GPR  = 32,
   parameter int PC_STEP  = 4,
   parameter bit ZERO_R0  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drv_alu,
   input  logic              drv_reg,
   input  logic              drv_mem,
   input  logic              drv_imm,
   input  logic              ld_ir,
   input  logic              ld_a,
   input  logic              ld_b,
   input  logic              ld_ma,
   input  logic [2:0]        reg_src,
   input  logic              reg_we,
   input  logic [1:0]        imm_mode,
   input  logic [1:0]        alu_fn,
   input  logic              mem_we,
   input  logic              mem_en,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_busy,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wr,
   output logic              mem_req,
   output logic              mem_wait,
   output logic [5:0]        opcode,
   output logic              a_zero,
   output logic              bus_conflict
);

   localparam int IDX_W    = $clog2(NUM_GPR + 1);
   localparam int FLD_W    = 5;
   localparam int OP_LSB   = 26;
   localparam int RS_LSB   = 21;
   localparam int RT_LSB   = 16;
   localparam int RD_LSB   = 11;
   localparam int IMM_W    = 16;
   localparam logic [IDX_W-1:0] PC_IDX   = IDX_W'(NUM_GPR);
   localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(NUM_GPR - 1);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("sbus_datapath: instruction field layout needs DATA_W == 32");
      end
      if (NUM_GPR > (1 << FLD_W)) begin : g_bad_gpr
         $error("sbus_datapath: register fields cannot reach all registers");
      end
   endgenerate

   logic [DATA_W-1:0] ir_q, a_q, b_q, ma_q;
   logic [DATA_W-1:0] bus_w, alu_y, reg_y, imm_y;
   logic [IDX_W-1:0]  reg_idx;
   logic              idx_ok;
   logic [NUM_DRIVERS-1:0] drv_vec;

   // register-file address decode
   always_comb begin
      idx_ok  = 1'b1;
      reg_idx = '0;
      unique case (reg_src_e'(reg_src))
         SRC_RS:   reg_idx = IDX_W'(ir_q[RS_LSB +: FLD_W]);
         SRC_RT:   reg_idx = IDX_W'(ir_q[RT_LSB +: FLD_W]);
         SRC_RD:   reg_idx = IDX_W'(ir_q[RD_LSB +: FLD_W]);
         SRC_PC:   reg_idx = PC_IDX;
         SRC_LINK: reg_idx = LINK_IDX;
         default:  idx_ok  = 1'b0;
      endcase
   end

   sbus_regfile #(
      .DATA_W  (DATA_W),
      .NUM_GPR (NUM_GPR),
      .ZERO_R0 (ZERO_R0),
      .IDX_W   (IDX_W)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .idx     (reg_idx),
      .idx_ok  (idx_ok),
      .wr_en   (reg_we),
      .wr_data (bus_w),
      .rd_data (reg_y)
   );

   sbus_alu #(
      .DATA_W (DATA_W),
      .STEP   (PC_STEP)
   ) u_alu (
      .a  (a_q),
      .b  (b_q),
      .fn (alu_fn),
      .y  (alu_y)
   );

   sbus_immext #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_imm (
      .field (ir_q[IMM_W-1:0]),
      .mode  (imm_mode),
      .y     (imm_y)
   );

   // shared bus: AND-OR of enabled sources
   assign drv_vec = {drv_imm, drv_mem, drv_reg, drv_alu};

   always_comb begin
      bus_w = ({DATA_W{drv_alu}} & alu_y)
            | ({DATA_W{drv_reg}} & reg_y)
            | ({DATA_W{drv_mem}} & mem_rdata)
            | ({DATA_W{drv_imm}} & imm_y);
   end

   assign bus_conflict = ($countones(drv_vec) > 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_q <= '0;
         a_q  <= '0;
         b_q  <= '0;
         ma_q <= '0;
      end else begin
         if (ld_ir) ir_q <= bus_w;
         if (ld_a)  a_q  <= bus_w;
         if (ld_b)  b_q  <= bus_w;
         if (ld_ma) ma_q <= bus_w;
      end
   end

   assign mem_addr  = ma_q;
   assign mem_wdata = bus_w;
   assign mem_wr    = mem_we;
   assign mem_req   = mem_en;
   assign mem_wait  = mem_busy;
   assign opcode    = ir_q[OP_LSB +: 6];
   assign a_zero    = (a_q == '0);

   // R4: instruction register takes the bus
   p_ir_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ir |=> ir_q == $past(bus_w));

   // R4: A holds without its strobe
   p_a_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_a |=> a_q == $past(a_q));

   // R6: entry 0 routed into A leaves A zero
   p_r0_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_a && drv_reg && !drv_alu && !drv_mem && !drv_imm && idx_ok && reg_idx == '0)
      |=> a_zero);

   // R9: address register feeds the memory port
   p_ma_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_ma |=> mem_addr == $past(bus_w));

   // R8: increment path lands in the address register
   p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ma && drv_alu && !drv_reg && !drv_mem && !drv_imm && alu_fn == ALU_STEP)
      |=> mem_addr == $past(a_q) + DATA_W'(PC_STEP));

endmodule

// File: tb/test_sbus_datapath.sv
`timescale 1ns/1ps
module test_sbus_datapath;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        drv_alu, drv_reg, drv_mem, drv_imm;
   logic        ld_ir, ld_a, ld_b, ld_ma;
   logic [2:0]  reg_src;
   logic        reg_we;
   logic [1:0]  imm_mode, alu_fn;
   logic        mem_we, mem_en, mem_busy;
   logic [31:0] mem_rdata;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_wr, mem_req, mem_wait;
   logic [5:0]  opcode;
   logic        a_zero, bus_conflict;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   sbus_datapath i_sbus_datapath (
      .clk(clk), .rst_n(rst_n),
      .drv_alu(drv_alu), .drv_reg(drv_reg), .drv_mem(drv_mem), .drv_imm(drv_imm),
      .ld_ir(ld_ir), .ld_a(ld_a), .ld_b(ld_b), .ld_ma(ld_ma),
      .reg_src(reg_src), .reg_we(reg_we), .imm_mode(imm_mode), .alu_fn(alu_fn),
      .mem_we(mem_we), .mem_en(mem_en), .mem_rdata(mem_rdata), .mem_busy(mem_busy),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr), .mem_req(mem_req),
      .mem_wait(mem_wait), .opcode(opcode), .a_zero(a_zero), .bus_conflict(bus_conflict)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic idle();
      drv_alu = 0; drv_reg = 0; drv_mem = 0; drv_imm = 0;
      ld_ir = 0; ld_a = 0; ld_b = 0; ld_ma = 0;
      reg_src = 3'd0; reg_we = 0; imm_mode = 2'd0; alu_fn = 2'd0;
      mem_we = 0; mem_en = 0; mem_busy = 0; mem_rdata = '0;
   endtask

   // drive a value from memory data into the chosen registers
   task automatic put(input logic [31:0] v, input bit lir, input bit la, input bit lb, input bit lma);
      drv_mem = 1; mem_rdata = v;
      ld_ir = lir; ld_a = la; ld_b = lb; ld_ma = lma;
      @(negedge clk);
      idle();
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [31:0] v);
      drv_mem = 1; mem_rdata = v; reg_src = sel; reg_we = 1;
      @(negedge clk);
      idle();
   endtask

   task automatic rd_reg(input logic [2:0] sel, output logic [31:0] v);
      drv_reg = 1; reg_src = sel;
      #1 v = mem_wdata;
      idle();
   endtask

   task automatic alu_out(input logic [1:0] fn, output logic [31:0] v);
      drv_alu = 1; alu_fn = fn;
      #1 v = mem_wdata;
      idle();
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 opcode", 32'(opcode), 32'd0);
      chk("R1 a_zero", 32'(a_zero), 32'd1);
      chk("R1 mem_addr", mem_addr, 32'd0);
      rd_reg(3'd3, v); chk("R1 pc entry", v, 32'd0);
      rd_reg(3'd4, v); chk("R1 link entry", v, 32'd0);
      alu_out(2'd1, v); chk("R1 A+B", v, 32'd0);
   endtask

   task automatic t_bus();
      #1 chk("R2 idle bus", mem_wdata, 32'd0);
      chk("R3 idle flag", 32'(bus_conflict), 32'd0);
      drv_mem = 1; mem_rdata = 32'hCAFE_1234;
      #1 chk("R2 mem source", mem_wdata, 32'hCAFE_1234);
      chk("R3 single", 32'(bus_conflict), 32'd0);
      drv_imm = 1;
      #1 chk("R3 two drivers", 32'(bus_conflict), 32'd1);
      drv_reg = 1; drv_alu = 1;
      #1 chk("R3 four drivers", 32'(bus_conflict), 32'd1);
      idle();
      #1 chk("R3 released", 32'(bus_conflict), 32'd0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      // opcode 0x23, rs=5, rt=6, rd=7, low bits 0x3800 from rd field
      put({6'h23, 5'd5, 5'd6, 5'd7, 11'd0}, 1, 0, 0, 0);
      chk("R10 opcode", 32'(opcode), 32'h23);
      wr_reg(3'd0, 32'h1111_0005);
      wr_reg(3'd1, 32'h2222_0006);
      wr_reg(3'd2, 32'h3333_0007);
      wr_reg(3'd3, 32'h0040_0000);
      wr_reg(3'd4, 32'h5555_001F);
      rd_reg(3'd0, v); chk("R5 rs entry", v, 32'h1111_0005);
      rd_reg(3'd1, v); chk("R5 rt entry", v, 32'h2222_0006);
      rd_reg(3'd2, v); chk("R5 rd entry", v, 32'h3333_0007);
      rd_reg(3'd3, v); chk("R5 pc entry", v, 32'h0040_0000);
      rd_reg(3'd4, v); chk("R5 link entry", v, 32'h5555_001F);
      // rs=31 must alias the link entry, rt=7 the rd value written above
      put({6'h02, 5'd31, 5'd7, 5'd5, 11'd0}, 1, 0, 0, 0);
      rd_reg(3'd0, v); chk("R5 rs=31 is link", v, 32'h5555_001F);
      rd_reg(3'd1, v); chk("R5 rt=7", v, 32'h3333_0007);
      rd_reg(3'd2, v); chk("R5 rd=5", v, 32'h1111_0005);
      chk("R10 opcode reload", 32'(opcode), 32'h02);
   endtask

   task automatic t_r0_and_bad_codes();
      logic [31:0] v;
      put({6'h00, 5'd0, 5'd0, 5'd0, 11'd0}, 1, 0, 0, 0);
      wr_reg(3'd0, 32'hDEAD_BEEF);
      rd_reg(3'd0, v); chk("R6 entry 0 reads zero", v, 32'd0);
      put(32'h7, 0, 1, 0, 0);
      chk("R10 a nonzero", 32'(a_zero), 32'd0);
      drv_reg = 1; reg_src = 3'd1; ld_a = 1;
      @(negedge clk); idle();
      chk("R6 A from entry 0", 32'(a_zero), 32'd1);
      wr_reg(3'd5, 32'h0BAD_0BAD);
      rd_reg(3'd5, v); chk("R11 code 5 reads zero", v, 32'd0);
      rd_reg(3'd7, v); chk("R11 code 7 reads zero", v, 32'd0);
      rd_reg(3'd3, v); chk("R11 pc untouched", v, 32'h0040_0000);
      rd_reg(3'd4, v); chk("R11 link untouched", v, 32'h5555_001F);
   endtask

   task automatic t_imm();
      put(32'hFC00_8004, 1, 0, 0, 0);
      drv_imm = 1; imm_mode = 2'd0;
      #1 chk("R7 sign ext neg", mem_wdata, 32'hFFFF_8004);
      imm_mode = 2'd1;
      #1 chk("R7 zero ext", mem_wdata, 32'h0000_8004);
      imm_mode = 2'd2;
      #1 chk("R7 sign ext shift", mem_wdata, 32'hFFFE_0010);
      imm_mode = 2'd3;
      #1 chk("R7 off", mem_wdata, 32'd0);
      idle();
      put(32'h0000_1234, 1, 0, 0, 0);
      drv_imm = 1; imm_mode = 2'd0;
      #1 chk("R7 sign ext pos", mem_wdata, 32'h0000_1234);
      imm_mode = 2'd2;
      #1 chk("R7 shift pos", mem_wdata, 32'h0000_48D0);
      idle();
   endtask

   task automatic t_alu();
      logic [31:0] v, a, b;
      a = 32'h1234_5678; b = 32'hABCD_EF01;
      put(a, 0, 1, 0, 0);
      put(b, 0, 0, 1, 0);
      alu_out(2'd0, v); chk("R8 pass A", v, a);
      alu_out(2'd1, v); chk("R8 A+B", v, a + b);
      alu_out(2'd2, v); chk("R8 A+4", v, a + 32'd4);
      alu_out(2'd3, v); chk("R8 jump target", v, {a[31:28], b[25:0], 2'b00});
      put(32'hFFFF_FFFE, 0, 1, 0, 0);
      alu_out(2'd2, v); chk("R8 A+4 wraps", v, 32'h0000_0002);
      alu_out(2'd1, v); chk("R4 B kept", v, 32'hFFFF_FFFE + b);
   endtask

   task automatic t_hold_and_mem();
      logic [31:0] v;
      put(32'h0000_0100, 0, 0, 0, 1);
      chk("R9 mem_addr", mem_addr, 32'h0000_0100);
      chk("R4 A kept", 32'(a_zero), 32'd0);
      // MA <- A + 4 through the ALU
      put(32'h0000_2000, 0, 1, 0, 0);
      drv_alu = 1; alu_fn = 2'd2; ld_ma = 1;
      @(negedge clk); idle();
      chk("R8 MA from A+4", mem_addr, 32'h0000_2004);
      mem_we = 1; mem_en = 1; mem_busy = 1;
      #1 chk("R9 wr pass", 32'(mem_wr), 32'd1);
      chk("R9 req pass", 32'(mem_req), 32'd1);
      chk("R9 wait pass", 32'(mem_wait), 32'd1);
      idle();
      #1 chk("R9 wait clear", 32'(mem_wait), 32'd0);
      rd_reg(3'd3, v); chk("R9 wdata is bus", v, 32'h0040_0000);
      chk("R4 MA kept", mem_addr, 32'h0000_2004);
      put(32'h0, 0, 1, 0, 0);
      chk("R10 a_zero after load 0", 32'(a_zero), 32'd1);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bus();
      t_regs();
      t_r0_and_bad_codes();
      t_imm();
      t_alu();
      t_hold_and_mem();
      done = 1'b1;
      summary();
      $finish;
   end

endmodule